// File: doc/BRIEF.md
# SPI Client Shift Engine

This block is the receive and transmit core for the client side of an SPI link. It follows an SCK supplied by the remote host. The select line is active low. Clock polarity, clock phase and bit order can each be chosen. The SCK, MOSI and select inputs pass through a short synchronizer into the local clock domain. The engine then detects SCK edges there, so SCK must be several times slower than the local clock.

Each received 8-bit character goes into a one-entry receive buffer. A transmit character is taken from a parallel input and shifted out on MISO. An optional addressed frame mode treats the first byte after select goes low as an address and compares it with a programmed value. On a mismatch, the rest of the frame is ignored. A receive overrun can be signalled in one of two ways: as soon as it happens, or later, at its place in the data stream.

Top module: `spi_client_engine`

## Requirements
- R1: After reset, `rxValid`, `ovfFlag` and `misoEn` are 0.
- R2: With `cpol`=0, SCK idles low and the leading edge is rising; with `cpol`=1, SCK idles high and the leading edge is falling. With `cpha`=0, MOSI is sampled on the leading edge and MISO changes on the trailing edge; with `cpha`=1, MOSI is sampled on the trailing edge and MISO changes on the leading edge.
- R3: With `lsbFirst`=0, bit 7 of each character is shifted first on both MOSI and MISO; with `lsbFirst`=1, bit 0 is shifted first.
- R4: While select is low, the first bit of `txData` is present on MISO before the first SCK edge of a character.
- R5: A completed character sets `rxValid` and appears on `rxData`. Both hold until a cycle with `rxRead`=1 clears `rxValid`.
- R6: If a character completes while `rxValid` is 1 and no read happens in that cycle, the new character is discarded. With `immOvf`=1, `ovfFlag` rises at once.
- R7: With `immOvf`=0, an overflow sets `ovfFlag` only when the buffered character that came before it is read.
- R8: `ovfFlag` stays at 1 until `ovfClr` is pulsed. The pulse also cancels a pending stream-order overflow.
- R9: With `frameFmt`=4'h2, the first byte of each frame is compared with `addrValue` and is not placed in the buffer. On a match, the later bytes of the frame are buffered. Any other `frameFmt` value gives plain frames in which every byte is buffered.
- R10: On an address mismatch, the rest of the frame is not buffered and MISO is driven high.
- R11: Raising `ssN` discards any partial character and restarts the frame, so the next byte is again the address in addressed mode.
- R12: With `enable`=0, or with `standby`=1 while `runStby`=0, the engine is idle at once, even in the middle of a character. Then `misoEn` is 0, nothing is received, and the partial bits are dropped. With `runStby`=1, `standby` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enable |
| standby | input | 1 | Standby sleep indication |
| runStby | input | 1 | Keep running in standby |
| cpol | input | 1 | Clock polarity (idle level of SCK) |
| cpha | input | 1 | Clock phase (0: sample on leading edge) |
| lsbFirst | input | 1 | Bit order (1: LSB first) |
| frameFmt | input | 4 | Frame format, 4'h2 selects addressed frames |
| immOvf | input | 1 | Overflow notification: 1 immediate, 0 stream order |
| addrValue | input | 8 | Address compared in addressed frames |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial data from host |
| ssN | input | 1 | Client select, active low |
| miso | output | 1 | Serial data to host |
| misoEn | output | 1 | MISO output enable |
| txData | input | 8 | Character to transmit |
| rxData | output | 8 | Receive buffer contents |
| rxValid | output | 1 | Receive buffer holds unread data |
| rxRead | input | 1 | Consume receive buffer |
| ovfFlag | output | 1 | Overflow status |
| ovfClr | input | 1 | Clear overflow status |

## Verification
The bench builds the engine with its default parameters: 8-bit characters and a two-stage synchronizer. SCK is driven at a half period of six local clocks, which leaves room for the synchronizer and edge-detect latency before each sampling point. With these settings, all four clock modes, both bit orders, back-to-back characters and overruns inside one frame can be reached. Select and standby can also be changed in the middle of a character, with MISO readable on every bit.

// File: rtl/spi_cl_pkg.sv
package spi_cl_pkg;
  typedef struct packed {
    logic frameRst;
    logic sampleEn;
    logic shiftEn;
  } engStrobe_t;

  localparam logic [3:0] FMT_ADDR = 4'h2;
endpackage

// File: rtl/spi_cl_datapath.sv
module spi_cl_datapath
  import spi_cl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        stb,
  input  logic              lsbFirst,
  input  logic              mosiS,
  input  logic              dropOut,
  input  logic [DATA_W-1:0] txData,
  output logic              miso,
  output logic              charDone,
  output logic [DATA_W-1:0] charByte
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] rxShift, txShift, rxNext;
  logic [CNT_W-1:0]  bitCnt;
  logic              haveSample;

  always_comb begin
    if (lsbFirst) rxNext = {mosiS, rxShift[DATA_W-1:1]};
    else          rxNext = {rxShift[DATA_W-2:0], mosiS};
  end

  assign charDone = stb.sampleEn && (bitCnt == LAST);
  assign charByte = rxNext;
  assign miso     = dropOut ? 1'b1 : (lsbFirst ? txShift[0] : txShift[DATA_W-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      bitCnt     <= '0;
      haveSample <= 1'b0;
    end else if (stb.frameRst) begin
      rxShift    <= '0;
      txShift    <= txData;
      bitCnt     <= '0;
      haveSample <= 1'b0;
    end else if (stb.sampleEn) begin
      rxShift    <= rxNext;
      bitCnt     <= (bitCnt == LAST) ? '0 : bitCnt + 1'b1;
      haveSample <= 1'b1;
    end else if (stb.shiftEn && haveSample) begin
      haveSample <= 1'b0;
      if (bitCnt == '0)  txShift <= txData;
      else if (lsbFirst) txShift <= txShift >> 1;
      else               txShift <= txShift << 1;
    end
  end
endmodule

// File: rtl/spi_cl_ctrl.sv
module spi_cl_ctrl
  import spi_cl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              standby,
  input  logic              runStby,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [3:0]        frameFmt,
  input  logic              immOvf,
  input  logic [DATA_W-1:0] addrValue,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ssN,
  input  logic              rxRead,
  input  logic              ovfClr,
  input  logic              charDone,
  input  logic [DATA_W-1:0] charByte,
  output engStrobe_t        stb,
  output logic              mosiS,
  output logic              dropOut,
  output logic              misoEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              ovfFlag
);
  logic [SYNC_STAGES-1:0] sckSync, mosiSync, ssSync;
  logic sckPrev, sckNow, sckRise, sckFall, leadEdge, trailEdge;
  logic active, selected, addrPhase, dropFrame, pendOvf, bufWrite, readNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      ssSync   <= '1;
      sckPrev  <= 1'b0;
    end else begin
      sckSync  <= {sckSync[SYNC_STAGES-2:0], sck};
      mosiSync <= {mosiSync[SYNC_STAGES-2:0], mosi};
      ssSync   <= {ssSync[SYNC_STAGES-2:0], ssN};
      sckPrev  <= sckNow;
    end
  end

  assign sckNow    = sckSync[SYNC_STAGES-1];
  assign mosiS     = mosiSync[SYNC_STAGES-1];
  assign sckRise   = sckNow & ~sckPrev;
  assign sckFall   = ~sckNow & sckPrev;
  assign leadEdge  = cpol ? sckFall : sckRise;
  assign trailEdge = cpol ? sckRise : sckFall;
  assign active    = enable && !(standby && !runStby);
  assign selected  = active && !ssSync[SYNC_STAGES-1];

  assign stb.frameRst = !selected;
  assign stb.sampleEn = selected && (cpha ? trailEdge : leadEdge);
  assign stb.shiftEn  = selected && (cpha ? leadEdge : trailEdge);

  assign misoEn   = selected;
  assign dropOut  = dropFrame;
  assign bufWrite = charDone && !addrPhase && !dropFrame;
  assign readNow  = rxRead && rxValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPhase <= 1'b0;
      dropFrame <= 1'b0;
    end else if (!selected) begin
      addrPhase <= (frameFmt == FMT_ADDR);
      dropFrame <= 1'b0;
    end else if (charDone && addrPhase) begin
      addrPhase <= 1'b0;
      dropFrame <= (charByte != addrValue);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      pendOvf <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (bufWrite && rxValid && !readNow) begin
        if (immOvf) ovfFlag <= 1'b1;
        else        pendOvf <= 1'b1;
      end else if (bufWrite) begin
        rxData  <= charByte;
        rxValid <= 1'b1;
      end else if (readNow) begin
        rxValid <= 1'b0;
      end
      if (readNow && pendOvf && !immOvf) begin
        ovfFlag <= 1'b1;
        pendOvf <= 1'b0;
      end
      if (ovfClr) begin
        ovfFlag <= 1'b0;
        pendOvf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_client_engine.sv
module spi_client_engine
  import spi_cl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              standby,
  input  logic              runStby,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  logic [3:0]        frameFmt,
  input  logic              immOvf,
  input  logic [DATA_W-1:0] addrValue,
  input  logic              sck,
  input  logic              mosi,
  input  logic              ssN,
  output logic              miso,
  output logic              misoEn,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxRead,
  output logic              ovfFlag,
  input  logic              ovfClr
);
  engStrobe_t        stb;
  logic              mosiS, dropOut, charDone;
  logic [DATA_W-1:0] charByte;

  spi_cl_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .standby(standby),
    .runStby(runStby), .cpol(cpol), .cpha(cpha), .frameFmt(frameFmt),
    .immOvf(immOvf), .addrValue(addrValue), .sck(sck), .mosi(mosi),
    .ssN(ssN), .rxRead(rxRead), .ovfClr(ovfClr), .charDone(charDone),
    .charByte(charByte), .stb(stb), .mosiS(mosiS), .dropOut(dropOut),
    .misoEn(misoEn), .rxData(rxData), .rxValid(rxValid), .ovfFlag(ovfFlag)
  );

  spi_cl_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .lsbFirst(lsbFirst), .mosiS(mosiS),
    .dropOut(dropOut), .txData(txData), .miso(miso), .charDone(charDone),
    .charByte(charByte)
  );
endmodule

// File: rtl/spi_cl_checker.sv
module spi_cl_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              immOvf,
  input logic              rxRead,
  input logic              ovfClr,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              ovfFlag
);
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxRead |=> rxValid && $stable(rxData)); // R5

  AST_STREAM_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    !immOvf && $rose(ovfFlag) |-> $past(rxRead)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !ovfClr |=> ovfFlag); // R8

  AST_IDLE_NO_RX: assert property (@(posedge clk) disable iff (!rstN)
    !enable && !rxValid |=> !rxValid); // R12
endmodule

bind spi_client_engine spi_cl_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .immOvf(immOvf), .rxRead(rxRead),
  .ovfClr(ovfClr), .rxValid(rxValid), .rxData(rxData), .ovfFlag(ovfFlag)
);

// File: tb/spi_client_engine_test.sv
module spi_client_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;

  logic clk = 0, rstN = 0;
  logic enable = 1, standby = 0, runStby = 0, cpol = 0, cpha = 0, lsbFirst = 0;
  logic [3:0] frameFmt = 4'h0;
  logic immOvf = 1;
  logic [7:0] addrValue = 8'h5A, txData = 8'h00;
  logic sck = 0, mosi = 0, ssN = 1, rxRead = 0, ovfClr = 0;
  logic miso, misoEn, rxValid, ovfFlag;
  logic [7:0] rxData;
  int checks = 0, errors = 0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_client_engine uut (
    .clk(clk), .rstN(rstN), .enable(enable), .standby(standby), .runStby(runStby),
    .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst), .frameFmt(frameFmt),
    .immOvf(immOvf), .addrValue(addrValue), .sck(sck), .mosi(mosi), .ssN(ssN),
    .miso(miso), .misoEn(misoEn), .txData(txData), .rxData(rxData),
    .rxValid(rxValid), .rxRead(rxRead), .ovfFlag(ovfFlag), .ovfClr(ovfClr)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bitPos(input int i, input logic lsb);
    return lsb ? i : 7 - i;
  endfunction

  task automatic setMode(input logic pol, input logic pha, input logic lsb);
    cpol = pol; cpha = pha; lsbFirst = lsb; sck = pol;
    tick(HALF);
  endtask

  task automatic frameStart();
    ssN = 0; tick(HALF);
  endtask

  task automatic frameEnd();
    tick(HALF); ssN = 1; tick(HALF);
  endtask

  task automatic xferBits(input logic [7:0] outB, input int n, output logic [7:0] inB);
    inB = '0;
    for (int i = 0; i < n; i++) begin
      int p;
      p = bitPos(i, lsbFirst);
      if (!cpha) begin
        mosi = outB[p]; tick(HALF);
        inB[p] = miso;
        sck = ~cpol; tick(HALF);
        sck = cpol;
      end else begin
        sck = ~cpol; mosi = outB[p]; tick(HALF);
        inB[p] = miso;
        sck = cpol; tick(HALF);
      end
    end
    tick(HALF);
  endtask

  task automatic readRx();
    rxRead = 1; tick(1); rxRead = 0; tick(1);
  endtask

  task automatic clearOvf();
    ovfClr = 1; tick(1); ovfClr = 0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(3); rstN = 1; tick(2);
    check("R1 rxValid", rxValid, 0);
    check("R1 ovfFlag", ovfFlag, 0);
    check("R1 misoEn", misoEn, 0);

    // R3 directed: MSB and LSB first, mode 0
    txData = 8'hC5; setMode(0, 0, 0); frameStart();
    check("R4 first bit before edge", miso, 1);
    xferBits(8'h81, 8, got);
    check("R3 msb rx", rxData, 8'h81); check("R3 msb tx", got, 8'hC5);
    readRx(); frameEnd();
    setMode(0, 0, 1); frameStart();
    check("R4 first bit lsb", miso, 1);
    xferBits(8'h81, 8, got);
    check("R3 lsb rx", rxData, 8'h81); check("R3 lsb tx", got, 8'hC5);
    readRx(); frameEnd();

    // R2 R5: random modes, multi-byte frames
    for (int it = 0; it < 40; it++) begin
      int nb;
      setMode($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      txData = 8'($urandom);
      nb = $urandom_range(1, 3);
      frameStart();
      for (int b = 0; b < nb; b++) begin
        logic [7:0] o;
        o = 8'($urandom);
        xferBits(o, 8, got);
        check("R2 rx byte", rxData, o);
        check("R5 rxValid set", rxValid, 1);
        check("R2 miso byte", got, txData);
        tick(3);
        check("R5 held", rxData, o);
        readRx();
        check("R5 cleared", rxValid, 0);
      end
      frameEnd();
    end

    // R6 immediate overflow
    setMode(1, 1, 0); immOvf = 1; txData = 8'h3C; frameStart();
    xferBits(8'hA1, 8, got); xferBits(8'hB2, 8, got);
    check("R6 imm flag", ovfFlag, 1);
    check("R6 first kept", rxData, 8'hA1);
    readRx(); check("R6 new discarded", rxValid, 0);
    frameEnd(); tick(5);
    check("R8 sticky", ovfFlag, 1);
    clearOvf(); check("R8 cleared", ovfFlag, 0);

    // R7 stream-order overflow
    immOvf = 0; frameStart();
    xferBits(8'h11, 8, got); xferBits(8'h22, 8, got);
    check("R7 not yet", ovfFlag, 0);
    check("R7 first kept", rxData, 8'h11);
    readRx();
    check("R7 flag after read", ovfFlag, 1);
    frameEnd(); clearOvf(); immOvf = 1;

    // R9 R10 R11 addressed frames
    frameFmt = 4'h2; setMode(0, 0, 0); txData = 8'h96;
    frameStart(); xferBits(8'h5A, 3, got); frameEnd();
    frameStart(); xferBits(8'h5A, 8, got);
    check("R9 address not buffered", rxValid, 0);
    check("R11 restart after partial", got, 8'h96);
    xferBits(8'h33, 8, got);
    check("R9 data buffered", rxData, 8'h33);
    check("R9 valid", rxValid, 1);
    readRx(); frameEnd();
    frameStart(); xferBits(8'h11, 8, got); xferBits(8'h44, 8, got);
    check("R10 mismatch dropped", rxValid, 0);
    check("R10 miso high", got, 8'hFF);
    frameEnd();
    frameStart(); xferBits(8'h5A, 8, got); xferBits(8'h77, 8, got);
    check("R11 new frame matches", rxData, 8'h77);
    readRx(); frameEnd();
    frameFmt = 4'h0;

    // R12 standby abort and enable
    setMode(0, 0, 0); runStby = 0; frameStart();
    xferBits(8'hF0, 4, got);
    standby = 1; tick(2);
    check("R12 standby idle", misoEn, 0);
    standby = 0; tick(HALF);
    check("R12 no partial", rxValid, 0);
    xferBits(8'h6B, 8, got);
    check("R12 partial dropped", rxData, 8'h6B);
    readRx(); frameEnd();
    runStby = 1; standby = 1; frameStart();
    xferBits(8'h4D, 8, got);
    check("R12 runStby keeps", rxData, 8'h4D);
    readRx(); frameEnd(); standby = 0;
    enable = 0; frameStart();
    check("R12 disabled misoEn", misoEn, 0);
    xferBits(8'h99, 8, got);
    check("R12 disabled no rx", rxValid, 0);
    frameEnd(); enable = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule